// File: doc/BRIEF.md
# Sync Error Rate Warning

This block turns a stream of single-cycle sync-error events from a video framer into one active-high warning flag. It does not react to any single bad sync. A leaky accumulator gains a fixed step for each error. It loses one unit at a programmable interval and one unit for each good sync. The flag compares the level against two programmable thresholds with hysteresis, so it rises once the error rate has stayed high and falls only after the level has drained well below the trip point.

The integrator stands in for a resistor-capacitor network and a Schmitt comparator. Its timing depends only on the clock and three settings, so there are no external components to tune. Software or a board strap supplies the leak interval and the two thresholds. The flag can be wired straight to a status pin or to an interrupt.

Top module: `sync_err_rate_warn`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator goes to zero and the warning flag goes to 0. Both stay that way until error pulses arrive after reset is released.
- R2: Each clock cycle with `sync_err_i` high adds `ERR_STEP` to the accumulator. The sum saturates at 2^`ACC_W`−1 and never wraps.
- R3: When `leak_period_i` = P > 0, an internal leak tick occurs every P clocks, counted from the release of reset. The tick removes one unit from the accumulator. When `leak_period_i` = 0, there is no timed leak.
- R4: The accumulator never goes below zero. A leak or good-sync decrement at level zero leaves it at zero.
- R5: Each clock cycle with `sync_ok_i` high removes one unit. When a good sync and a leak tick fall in the same cycle, only one unit is removed.
- R6: When `sync_err_i` is high, any decrement in that same cycle (leak tick or good sync) is dropped. Only the increment applies.
- R7: The flag is 1 after any clock edge at which the updated accumulator is ≥ `warn_hi_i`.
- R8: Once set, the flag stays 1 while the updated accumulator is > `warn_lo_i`. It returns to 0 at the first edge where the level is ≤ `warn_lo_i` and below `warn_hi_i`.
- R9: `warn_o` is a register. It reflects the level reached at a clock edge and does not change between edges in response to input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_err_i | input | 1 | One-cycle pulse per sync error |
| sync_ok_i | input | 1 | One-cycle pulse per valid sync |
| leak_period_i | input | PER_W | Clocks between leak ticks; 0 disables timed leak |
| warn_hi_i | input | ACC_W | Level at or above which the flag sets |
| warn_lo_i | input | ACC_W | Level at or below which a set flag clears |
| warn_o | output | 1 | Registered active-high warning flag |

## Verification
The bench targets the following corner cases:

- **Saturation at full scale.** An accumulator that wraps instead of clamping would fall back to a low value. It would then never reach the top threshold.
- **The zero floor.** A design that underflows would jump near full scale and raise a false warning.
- **Same-cycle collisions.** A design that lets a leak cancel part of an increment, or that removes two units for one good sync plus a tick, would cross a threshold one step late or early.
- **Hysteresis sweeps over threshold pairs and every leak period.** An off-by-one in the comparisons, or in the leak counter, shifts the exact cycle at which the flag rises or falls.

// File: rtl/sewarn_pkg.sv
package sewarn_pkg;
  typedef enum logic [1:0] {
    LVL_HOLD = 2'd0,
    LVL_INC  = 2'd1,
    LVL_DEC  = 2'd2
  } lvl_op_e;
endpackage

// File: rtl/sewarn_leak_timer.sv
module sewarn_leak_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;
  logic             active;
  logic             at_end;

  assign active = (period_i != '0);
  assign at_end = active && (cnt_q >= period_i - PER_W'(1));
  assign tick_o = at_end;

  always_ff @(posedge clk) begin
    if (rst || !active || at_end) cnt_q <= '0;
    else                          cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/sewarn_accum.sv
module sewarn_accum
  import sewarn_pkg::*;
#(
  parameter int ACC_W    = 8,
  parameter int ERR_STEP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  lvl_op_e          op_i,
  output logic [ACC_W-1:0] lvl_o,
  output logic [ACC_W-1:0] lvl_next_o
);
  localparam logic [ACC_W:0] STEP_EXT = (ACC_W+1)'(ERR_STEP);

  logic [ACC_W-1:0] lvl_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, lvl_q} + STEP_EXT;

  always_comb begin
    lvl_next_o = lvl_q;
    unique case (op_i)
      LVL_INC: lvl_next_o = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
      LVL_DEC: lvl_next_o = (lvl_q == '0) ? '0 : lvl_q - ACC_W'(1);
      default: lvl_next_o = lvl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_next_o;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/sewarn_hyst.sv
module sewarn_hyst #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] lvl_i,
  input  logic [ACC_W-1:0] hi_i,
  input  logic [ACC_W-1:0] lo_i,
  output logic             flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= (lvl_i >= hi_i) || (flag_q && (lvl_i > lo_i));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sync_err_rate_warn.sv
module sync_err_rate_warn
  import sewarn_pkg::*;
#(
  parameter int ACC_W    = 8,
  parameter int ERR_STEP = 16,
  parameter int PER_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_err_i,
  input  logic             sync_ok_i,
  input  logic [PER_W-1:0] leak_period_i,
  input  logic [ACC_W-1:0] warn_hi_i,
  input  logic [ACC_W-1:0] warn_lo_i,
  output logic             warn_o
);
  logic             leak_tick;
  lvl_op_e          op;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;

  sewarn_leak_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .period_i(leak_period_i), .tick_o(leak_tick)
  );

  always_comb begin
    if (sync_err_i)                  op = LVL_INC;
    else if (leak_tick || sync_ok_i) op = LVL_DEC;
    else                             op = LVL_HOLD;
  end

  sewarn_accum #(.ACC_W(ACC_W), .ERR_STEP(ERR_STEP)) u_accum (
    .clk(clk), .rst(rst), .op_i(op), .lvl_o(acc_q), .lvl_next_o(acc_next)
  );

  sewarn_hyst #(.ACC_W(ACC_W)) u_hyst (
    .clk(clk), .rst(rst), .lvl_i(acc_next), .hi_i(warn_hi_i),
    .lo_i(warn_lo_i), .flag_o(warn_o)
  );
endmodule

// File: rtl/sewarn_checker.sv
module sewarn_checker #(
  parameter int ACC_W    = 8,
  parameter int ERR_STEP = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             err,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] hi,
  input logic [ACC_W-1:0] lo,
  input logic             flag
);
  localparam int MAXV = (1 << ACC_W) - 1;

  p_rst_clear_r1: assert property (@(posedge clk) rst |=> (acc == '0 && !flag));

  p_sat_add_r2: assert property (@(posedge clk) disable iff (rst)
    err |=> (int'(acc) == ((int'($past(acc)) + ERR_STEP > MAXV) ? MAXV
                                                              : int'($past(acc)) + ERR_STEP)));

  p_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (!err && acc == '0) |=> (acc == '0));

  p_one_step_r5: assert property (@(posedge clk) disable iff (rst)
    !err |=> (acc == $past(acc) || int'(acc) == int'($past(acc)) - 1));

  p_set_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((acc >= $past(hi)) -> flag));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flag) && acc > $past(lo)) -> flag));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((acc <= $past(lo) && acc < $past(hi)) -> !flag));
endmodule

bind sync_err_rate_warn sewarn_checker #(.ACC_W(ACC_W), .ERR_STEP(ERR_STEP)) u_chk (
  .clk(clk), .rst(rst), .err(sync_err_i), .acc(acc_q),
  .hi(warn_hi_i), .lo(warn_lo_i), .flag(warn_o)
);

// File: tb/test_sync_err_rate_warn.sv
module test_sync_err_rate_warn;
  localparam int ACC_W = 6;
  localparam int STEP  = 8;
  localparam int PER_W = 4;
  localparam int MAXV  = (1 << ACC_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             err = 1'b0;
  logic             ok  = 1'b0;
  logic [PER_W-1:0] per = '0;
  logic [ACC_W-1:0] hi  = '0;
  logic [ACC_W-1:0] lo  = '0;
  logic             warn;

  int checks = 0;
  int errors = 0;
  int m_acc = 0, m_cnt = 0;
  logic m_flag = 1'b0;

  always #2.5ns clk = ~clk;

  sync_err_rate_warn #(.ACC_W(ACC_W), .ERR_STEP(STEP), .PER_W(PER_W)) i_sync_err_rate_warn (
    .clk(clk), .rst(rst), .sync_err_i(err), .sync_ok_i(ok), .leak_period_i(per),
    .warn_hi_i(hi), .warn_lo_i(lo), .warn_o(warn)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t warn actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic model_step();
    logic tick;
    tick = (per != 0) && (m_cnt >= int'(per) - 1);
    m_cnt = (per == 0 || tick) ? 0 : m_cnt + 1;
    if (err) m_acc = (m_acc + STEP > MAXV) ? MAXV : m_acc + STEP;
    else if ((tick || ok) && m_acc > 0) m_acc = m_acc - 1;
    m_flag = (m_acc >= int'(hi)) || (m_flag && m_acc > int'(lo));
  endtask

  task automatic cyc(input logic e, input logic o, input string tag);
    err = e; ok = o;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(warn, m_flag, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; err = 1'b0; ok = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_cnt = 0; m_flag = 1'b0;
    chk(warn, 1'b0, "R1 reset");
  endtask

  initial begin
    #(200000 * 5ns);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: saturation, no leak, trip point at full scale
    per = 0; hi = 6'(MAXV); lo = 0;
    for (int k = 0; k < 7; k++) cyc(1, 0, "R2 below full");
    chk(warn, 1'b0, "R2 seven steps");
    cyc(1, 0, "R2 saturate");
    chk(warn, 1'b1, "R2 reaches max");
    for (int k = 0; k < 3; k++) cyc(1, 0, "R2 stays saturated");

    // R1: reset in mid-run clears flag and level
    do_reset();
    hi = 6'd8;
    cyc(1, 0, "R1 after reset level zero");
    chk(warn, 1'b1, "R1 single step from zero");

    // R4: floor at zero
    do_reset();
    per = 0; hi = 6'd8; lo = 0;
    for (int k = 0; k < 10; k++) cyc(0, 1, "R4 drain at zero");
    cyc(1, 0, "R4 step after floor");
    chk(warn, 1'b1, "R4 no underflow");
    for (int k = 0; k < 7; k++) cyc(0, 1, "R4 drain");
    chk(warn, 1'b1, "R8 level one above lo");
    cyc(0, 1, "R8 reach lo");
    chk(warn, 1'b0, "R8 clears at lo");

    // R5: good syncs drain, single unit with coincident tick
    do_reset();
    per = 0; hi = 6'd24; lo = 6'd16;
    for (int k = 0; k < 3; k++) cyc(1, 0, "R5 fill");
    for (int k = 0; k < 8; k++) cyc(0, 1, "R5 sync drain");
    chk(warn, 1'b0, "R5 eight syncs to lo");
    do_reset();
    per = 4'd1; hi = 6'd16; lo = 6'd12;
    cyc(1, 0, "R5 fill a");
    cyc(1, 0, "R5 fill b");
    for (int k = 0; k < 3; k++) cyc(0, 1, "R5 tick plus sync");
    chk(warn, 1'b1, "R5 one unit per cycle");
    cyc(0, 1, "R5 tick plus sync");
    chk(warn, 1'b0, "R5 one unit per cycle end");

    // R6: increment wins over same-cycle decrement
    do_reset();
    per = 4'd1; hi = 6'd16; lo = 0;
    cyc(1, 1, "R6 err with sync");
    cyc(1, 1, "R6 err with sync");
    chk(warn, 1'b1, "R6 no drop of increment");

    // R3: every leak period, flag clears when drained
    for (int p = 0; p < 16; p++) begin
      do_reset();
      per = 4'(p); hi = 6'd8; lo = 0;
      cyc(1, 0, "R3 load");
      for (int k = 0; k < 130; k++) cyc(0, 0, "R3 leak timing");
      if (p == 0) chk(warn, 1'b1, "R3 no leak when zero");
      else        chk(warn, 1'b0, "R3 drained");
    end

    // R9: output does not move before the edge
    do_reset();
    per = 0; hi = 6'd8; lo = 0;
    err = 1'b1; #1ns;
    chk(warn, 1'b0, "R9 registered output");
    cyc(1, 0, "R9 after edge");

    // R7 / R8: threshold sweep with mixed drain
    for (int h = 8; h <= 56; h += 8) begin
      for (int l = 0; l < h; l += 5) begin
        do_reset();
        per = 4'd3; hi = 6'(h); lo = 6'(l);
        for (int k = 0; k < h / 8; k++) cyc(1, 0, "R7 rise to hi");
        for (int k = 0; k < 70; k++) cyc(0, (k % 3) == 0, "R8 hysteresis fall");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule